// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side serial port of a NOR flash model. It watches a serial clock, a chip select and a data-in line, all sampled by a faster system clock. Every rising serial-clock edge while chip select is low shifts one bit in, most significant bit first. The first byte of each transaction is an opcode. Depending on the opcode, the block then collects a 24-bit address, a dummy byte or data bytes, or shifts read data out on falling edges.

Read-type commands take their bytes from the back end as they go, and the master may end them after any bit. Write-type commands are only handed to the back-end array controller as a one-cycle strobe. That strobe is issued only when chip select rises after a whole number of bytes and after every byte the command needs. Any other ending discards the command. Page-program data bytes are streamed to the back end as they arrive, and the commit strobe tells the back end to act on them.

Top module: `sfe_cmd_frontend`

## Requirements
- R1: While `csn` is low, each rising edge of `sck` shifts `sdi` in, most significant bit first. Eight edges form one byte, and the first byte is the opcode.
- R2: Opcode 03h takes three address bytes, most significant first. It then shifts out `rd_data` for the address on `rd_addr`, one byte per eight clocks. The address steps by one per byte and wraps from FFFFFFh to 000000h.
- R3: Opcode 0Bh takes three address bytes and then one ignored dummy byte before its data bytes, which follow the same rules as R2.
- R4: Opcode 05h shifts out `status_in` again and again, taking a fresh copy at the start of each output byte.
- R5: Opcode 9Fh shifts out the bytes of parameter `ID_WORD`, most significant byte first, and then 00h for every further byte.
- R6: Each output bit appears on `sdo` after a falling edge of `sck`. The first bit follows the falling edge right after the last input bit. `sdo` is 0 while `csn` is high and outside output phases.
- R7: Opcode 02h takes three address bytes, and each later byte appears on `wdat` with a one-cycle `wdat_vld`. A commit carries `cmd_op`=4 and the start address on `cmd_addr`, and it needs at least one data byte.
- R8: Opcodes 06h, 04h and C7h commit with `cmd_op` 1, 2 and 6 respectively when `csn` rises after whole bytes. Any extra whole bytes are ignored. `cmd_vld` lasts one clock cycle.
- R9: Opcode D8h commits with `cmd_op`=5 and the address after three address bytes. Opcode 01h commits with `cmd_op`=3 and its one data byte on `cmd_data`.
- R10: For a write-type opcode, no `cmd_vld` is issued when `csn` rises after a bit count that is not a multiple of eight, or before all required bytes have arrived.
- R11: A read-type command may be ended after any bit. This gives no `cmd_vld`, and the output bits up to that point follow R2 to R5.
- R12: For an unknown opcode, the block drives `sdo` at 0 and gives no `wdat_vld` or `cmd_vld` until `csn` rises. The next transaction decodes normally.
- R13: `csn` high clears the bit count and the command state, so a transaction cut short leaves nothing behind for the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| csn | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| rd_addr | output | 24 | Address of the next read byte |
| rd_data | input | 8 | Array byte at `rd_addr` |
| status_in | input | 8 | Status byte from the back end |
| wdat_vld | output | 1 | Page-program data byte strobe |
| wdat | output | 8 | Page-program data byte |
| cmd_vld | output | 1 | Write-type command commit strobe |
| cmd_op | output | 4 | Committed command code (1..6) |
| cmd_addr | output | 24 | Committed address |
| cmd_data | output | 8 | Committed status data byte |

## Verification
Directed transactions cover each opcode on its own. An identification read that runs past the identifier separates the ID bytes from the zero padding. A status read during which the status changes shows whether the status is copied per byte or only once. A read that starts at FFFFFEh exposes a missing address wrap. Stray bits before a write enable, followed by the write enable itself, separate a counter that clears on chip select from one that does not. Random reads with random lengths and abort points, and random write commands cut at random bit counts, are compared against the commit rule computed in the bench. These show whether a commit depends on byte alignment, on the minimum byte count, or on both.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    CMD_NONE = 4'd0,
    CMD_WREN = 4'd1,
    CMD_WRDI = 4'd2,
    CMD_WRSR = 4'd3,
    CMD_PP   = 4'd4,
    CMD_SE   = 4'd5,
    CMD_BE   = 4'd6,
    CMD_READ = 4'd7,
    CMD_FAST = 4'd8,
    CMD_RDSR = 4'd9,
    CMD_RDID = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_WDATA,
    PH_TX,
    PH_HOLD,
    PH_IGN
  } phase_e;

  function automatic cmd_e decode_op(input logic [BYTE_W-1:0] b);
    case (b)
      8'h03:   return CMD_READ;
      8'h0B:   return CMD_FAST;
      8'h05:   return CMD_RDSR;
      8'h9F:   return CMD_RDID;
      8'h02:   return CMD_PP;
      8'hD8:   return CMD_SE;
      8'hC7:   return CMD_BE;
      8'h01:   return CMD_WRSR;
      8'h06:   return CMD_WREN;
      8'h04:   return CMD_WRDI;
      default: return CMD_NONE;
    endcase
  endfunction

  function automatic phase_e ph_after_op(input cmd_e c);
    case (c)
      CMD_READ, CMD_FAST, CMD_PP, CMD_SE: return PH_ADDR;
      CMD_RDSR, CMD_RDID:                 return PH_TX;
      CMD_WRSR:                           return PH_WDATA;
      CMD_WREN, CMD_WRDI, CMD_BE:         return PH_HOLD;
      default:                            return PH_IGN;
    endcase
  endfunction

  function automatic phase_e ph_after_addr(input cmd_e c);
    case (c)
      CMD_READ: return PH_TX;
      CMD_FAST: return PH_DUMMY;
      CMD_PP:   return PH_WDATA;
      CMD_SE:   return PH_HOLD;
      default:  return PH_IGN;
    endcase
  endfunction

  function automatic logic is_array_read(input cmd_e c);
    return (c == CMD_READ) || (c == CMD_FAST);
  endfunction

endpackage

// File: rtl/sfe_edge.sv
module sfe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);

  logic sck_d;
  logic csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_d <= sck;
      csn_d <= csn;
    end
  end

  assign sel      = !csn;
  assign sck_rise = sel && sck && !sck_d;
  assign sck_fall = sel && !sck && sck_d;
  assign cs_rise  = csn && !csn_d;

endmodule

// File: rtl/sfe_rx.sv
module sfe_rx #(
  parameter int BW = 8,
  localparam int CW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sck_rise,
  input  logic          sdi,
  output logic [CW-1:0] bit_cnt,
  output logic          byte_done,
  output logic [BW-1:0] byte_val
);

  logic [BW-2:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      bit_cnt <= '0;
    end else if (!sel) begin
      sr      <= '0;
      bit_cnt <= '0;
    end else if (sck_rise) begin
      sr      <= {sr[BW-3:0], sdi};
      bit_cnt <= (bit_cnt == CW'(BW-1)) ? '0 : bit_cnt + CW'(1);
    end
  end

  assign byte_done = sck_rise && (bit_cnt == CW'(BW-1));
  assign byte_val  = {sr, sdi};

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bit_cnt == '0)); // R13

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && sck_rise && bit_cnt != CW'(BW-1)) |=> (bit_cnt == $past(bit_cnt) + CW'(1))); // R1

endmodule

// File: rtl/sfe_tx.sv
module sfe_tx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          shift,
  input  logic          load,
  input  logic [BW-1:0] load_val,
  output logic          sdo
);

  logic [BW-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx <= '0;
    else if (!sel)   tx <= '0;
    else if (load)   tx <= load_val;
    else if (shift)  tx <= {tx[BW-2:0], 1'b0};
  end

  assign sdo = tx[BW-1];

  AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !sdo); // R6

  AST_TX_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && shift && !load) |=> (sdo == $past(tx[BW-2]))); // R6

endmodule

// File: rtl/sfe_cmd_frontend.sv
module sfe_cmd_frontend
  import sfe_pkg::*;
#(
  parameter int                     ADDR_BYTES = 3,
  parameter int                     ID_BYTES   = 3,
  parameter logic [8*ID_BYTES-1:0]  ID_WORD    = 24'hC25A3E
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sck,
  input  logic                    csn,
  input  logic                    sdi,
  output logic                    sdo,
  output logic [8*ADDR_BYTES-1:0] rd_addr,
  input  logic [7:0]              rd_data,
  input  logic [7:0]              status_in,
  output logic                    wdat_vld,
  output logic [7:0]              wdat,
  output logic                    cmd_vld,
  output logic [3:0]              cmd_op,
  output logic [8*ADDR_BYTES-1:0] cmd_addr,
  output logic [7:0]              cmd_data
);

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int ID_W   = 8 * ID_BYTES;
  localparam int ABC_W  = $clog2(ADDR_BYTES + 1);
  localparam int IDX_W  = $clog2(ID_BYTES + 1);
  localparam int CW     = $clog2(BYTE_W);

  // named internal events
  logic              sel, sck_rise, sck_fall, cs_rise;
  logic [CW-1:0]     bit_cnt;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              tx_load, tx_shift, commit_ok;
  logic [BYTE_W-1:0] tx_val;

  phase_e            phase;
  cmd_e              cur_op;
  logic [ADDR_W-1:0] addr_q;
  logic [ABC_W-1:0]  acnt;
  logic [IDX_W-1:0]  id_idx;
  logic              pp_seen;
  logic [7:0]        wrsr_q;

  function automatic logic [7:0] id_pick(input logic [IDX_W-1:0] idx);
    logic [ID_W-1:0] sh;
    if (int'(idx) >= ID_BYTES) return 8'h00;
    sh = ID_WORD << (8 * int'(idx));
    return sh[ID_W-1 -: 8];
  endfunction

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  sfe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .csn      (csn),
    .sel      (sel),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise)
  );

  sfe_rx #(.BW(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .sck_rise  (sck_rise),
    .sdi       (sdi),
    .bit_cnt   (bit_cnt),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  assign tx_shift = sck_fall && (phase == PH_TX);
  assign tx_load  = tx_shift && (bit_cnt == '0);

  always_comb begin
    case (cur_op)
      CMD_READ, CMD_FAST: tx_val = rd_data;
      CMD_RDSR:           tx_val = status_in;
      CMD_RDID:           tx_val = id_pick(id_idx);
      default:            tx_val = '0;
    endcase
  end

  sfe_tx #(.BW(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .shift    (tx_shift),
    .load     (tx_load),
    .load_val (tx_val),
    .sdo      (sdo)
  );

  assign commit_ok = cs_rise && (bit_cnt == '0) &&
                     ((phase == PH_HOLD) || ((phase == PH_WDATA) && pp_seen));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OPC;
      cur_op   <= CMD_NONE;
      addr_q   <= '0;
      acnt     <= '0;
      id_idx   <= '0;
      pp_seen  <= 1'b0;
      wrsr_q   <= '0;
      wdat_vld <= 1'b0;
      wdat     <= '0;
      cmd_vld  <= 1'b0;
      cmd_op   <= '0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      cmd_vld  <= commit_ok;
      wdat_vld <= 1'b0;
      if (commit_ok) begin
        cmd_op   <= cur_op;
        cmd_addr <= addr_q;
        cmd_data <= wrsr_q;
      end
      if (!sel) begin
        phase   <= PH_OPC;
        cur_op  <= CMD_NONE;
        acnt    <= '0;
        id_idx  <= '0;
        pp_seen <= 1'b0;
      end else begin
        if (byte_done) begin
          case (phase)
            PH_OPC: begin
              cur_op <= decode_op(byte_val);
              phase  <= ph_after_op(decode_op(byte_val));
              acnt   <= '0;
            end
            PH_ADDR: begin
              addr_q <= ADDR_W'({addr_q, byte_val});
              if (acnt == ABC_W'(ADDR_BYTES - 1)) phase <= ph_after_addr(cur_op);
              else acnt <= acnt + ABC_W'(1);
            end
            PH_DUMMY: phase <= PH_TX;
            PH_WDATA: begin
              if (cur_op == CMD_PP) begin
                wdat_vld <= 1'b1;
                wdat     <= byte_val;
                pp_seen  <= 1'b1;
              end else begin
                wrsr_q <= byte_val;
                phase  <= PH_HOLD;
              end
            end
            default: ;
          endcase
        end
        if (tx_load && is_array_read(cur_op)) addr_q <= addr_inc(addr_q);
        if (tx_load && (cur_op == CMD_RDID) && (id_idx != IDX_W'(ID_BYTES)))
          id_idx <= id_idx + IDX_W'(1);
      end
    end
  end

  assign rd_addr = addr_q;

  AST_WDAT_PP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wdat_vld |-> (cur_op == CMD_PP)); // R7

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld); // R8

  AST_CMD_WRITE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (cmd_op >= 4'd1 && cmd_op <= 4'd6)); // R8

  AST_CMD_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> csn); // R10

  AST_RDADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && is_array_read(cur_op)) |=> (rd_addr == addr_inc($past(rd_addr)))); // R2

  AST_IGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN) |-> (!sdo && !wdat_vld)); // R12

endmodule

// File: tb/sfe_cmd_frontend_tb.sv
`timescale 1ns/1ps
module sfe_cmd_frontend_tb_top;

  localparam logic [23:0] IDW = 24'hC25A3E;
  localparam int WDOG = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        csn = 1'b1;
  logic        sdi = 1'b0;
  logic [7:0]  status_in = 8'h00;
  wire         sdo;
  wire  [23:0] rd_addr;
  wire  [7:0]  rd_data;
  wire         wdat_vld;
  wire  [7:0]  wdat;
  wire         cmd_vld;
  wire  [3:0]  cmd_op;
  wire  [23:0] cmd_addr;
  wire  [7:0]  cmd_data;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  assign rd_data = mem_byte(rd_addr);

  sfe_cmd_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .sdi(sdi), .sdo(sdo),
    .rd_addr(rd_addr), .rd_data(rd_data), .status_in(status_in),
    .wdat_vld(wdat_vld), .wdat(wdat), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  int          cmd_cnt = 0;
  logic [3:0]  l_op;
  logic [23:0] l_addr;
  logic [7:0]  l_data;
  int          wcnt = 0;
  logic [7:0]  wlog [64];
  logic [7:0]  pay [8];

  always @(negedge clk) begin
    if (cmd_vld) begin
      cmd_cnt = cmd_cnt + 1;
      l_op = cmd_op; l_addr = cmd_addr; l_data = cmd_data;
    end
    if (wdat_vld) begin
      wlog[wcnt % 64] = wdat;
      wcnt = wcnt + 1;
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG && !finished) begin
      errors = errors + 1;
      $display("FAIL R0 watchdog actual=%0d expected<%0d", cyc, WDOG);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    sck = 1'b0; csn = 1'b0; wclk(4);
  endtask

  task automatic cs_hi();
    sck = 1'b0; wclk(2); csn = 1'b1; wclk(6);
  endtask

  task automatic bit_io(input logic b, output logic o);
    sck = 1'b0; sdi = b; wclk(4);
    o = sdo;
    sck = 1'b1; wclk(4);
  endtask

  task automatic byte_io(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) bit_io(d[i], q[i]);
  endtask

  function automatic logic [3:0] op_code(input logic [7:0] op);
    case (op)
      8'h06: return 4'd1; 8'h04: return 4'd2; 8'h01: return 4'd3;
      8'h02: return 4'd4; 8'hD8: return 4'd5; 8'hC7: return 4'd6;
      default: return 4'd0;
    endcase
  endfunction

  function automatic int min_after_op(input logic [7:0] op);
    case (op)
      8'h01: return 1; 8'hD8: return 3; 8'h02: return 4;
      default: return 0;
    endcase
  endfunction

  // R2, R3, R11 (and R1 through the address decode)
  task automatic do_read(input logic fast, input logic [23:0] a, input int nb, input int abits);
    logic [7:0] q; logic o; int c0, w0;
    c0 = cmd_cnt; w0 = wcnt;
    cs_lo();
    byte_io(fast ? 8'h0B : 8'h03, q);
    byte_io(a[23:16], q); byte_io(a[15:8], q); byte_io(a[7:0], q);
    if (fast) byte_io(8'hFF, q);
    for (int k = 0; k < nb; k++) begin
      byte_io(8'h00, q);
      check(fast ? "R3 fast read byte" : "R2 read byte", {24'h0, q}, {24'h0, mem_byte(a + 24'(k))});
    end
    for (int i = 0; i < abits; i++) begin
      bit_io(1'b0, o);
      check("R11 partial bit", {31'h0, o}, {31'h0, mem_byte(a + 24'(nb))[7-i]});
    end
    cs_hi();
    check("R11 read gives no commit", cmd_cnt - c0, 0);
    check("R11 read gives no wdat", wcnt - w0, 0);
  endtask

  // R7, R8, R9, R10
  task automatic do_write(input logic [7:0] op, input int nb, input int xbits);
    logic [7:0] q; logic o; int c0, w0; bit exp_commit; int nd;
    c0 = cmd_cnt; w0 = wcnt;
    cs_lo();
    byte_io(op, q);
    for (int i = 0; i < nb; i++) byte_io(pay[i], q);
    for (int i = 0; i < xbits; i++) bit_io(1'b1, o);
    cs_hi();
    exp_commit = (xbits == 0) && (nb >= min_after_op(op));
    check("R10 commit rule", cmd_cnt - c0, exp_commit ? 1 : 0);
    if (exp_commit && cmd_cnt - c0 == 1) begin
      check("R8 command code", {28'h0, l_op}, {28'h0, op_code(op)});
      if (op == 8'h02 || op == 8'hD8)
        check("R9 commit address", {8'h0, l_addr}, {8'h0, pay[0], pay[1], pay[2]});
      if (op == 8'h01) check("R9 status data", {24'h0, l_data}, {24'h0, pay[0]});
    end
    nd = (op == 8'h02 && nb > 3) ? nb - 3 : 0;
    check("R7 wdat count", wcnt - w0, nd);
    for (int i = 0; i < nd && (wcnt - w0) == nd; i++)
      check("R7 wdat byte", {24'h0, wlog[(w0 + i) % 64]}, {24'h0, pay[3 + i]});
  endtask

  initial begin
    logic [7:0] q; logic o; int c0, w0;
    logic [7:0] wops [6];
    wops[0] = 8'h06; wops[1] = 8'h04; wops[2] = 8'h01;
    wops[3] = 8'h02; wops[4] = 8'hD8; wops[5] = 8'hC7;
    void'($urandom(32'd4711));
    wclk(3);
    rst_n = 1'b1;
    wclk(3);
    check("R6 reset sdo", {31'h0, sdo}, 0);
    check("R8 reset cmd_vld", {31'h0, cmd_vld}, 0);
    check("R7 reset wdat_vld", {31'h0, wdat_vld}, 0);

    // R5 identification with padding
    cs_lo(); byte_io(8'h9F, q);
    for (int k = 0; k < 5; k++) begin
      byte_io(8'h00, q);
      check("R5 id byte", {24'h0, q}, {24'h0, (k < 3) ? IDW[23 - 8*k -: 8] : 8'h00});
    end
    cs_hi();
    check("R6 idle sdo", {31'h0, sdo}, 0);

    // R4 status copied at each byte
    cs_lo(); byte_io(8'h05, q);
    for (int k = 0; k < 3; k++) begin
      status_in = 8'h81 + 8'(k * 37);
      byte_io(8'h00, q);
      check("R4 status byte", {24'h0, q}, {24'h0, 8'h81 + 8'(k * 37)});
    end
    cs_hi();

    // R2 address wrap, R3 fast read, R11 abort
    do_read(1'b0, 24'hFFFFFE, 4, 0);
    do_read(1'b1, 24'h12345F, 2, 3);

    // R12 unknown opcode
    c0 = cmd_cnt; w0 = wcnt;
    cs_lo(); byte_io(8'hAB, q);
    for (int k = 0; k < 4; k++) begin
      byte_io(8'h5A, q);
      check("R12 sdo silent", {24'h0, q}, 0);
    end
    cs_hi();
    check("R12 no commit", cmd_cnt - c0, 0);
    check("R12 no wdat", wcnt - w0, 0);

    // R13 stray bits then write enable
    cs_lo(); for (int i = 0; i < 3; i++) bit_io(1'b1, o); cs_hi();
    do_write(8'h06, 0, 0);

    // directed write cases: R9 sector erase short, R7 page program w/o data, R10 misaligned
    for (int i = 0; i < 8; i++) pay[i] = 8'(8'h10 * i + 3);
    do_write(8'hD8, 2, 0);
    do_write(8'hD8, 3, 0);
    do_write(8'h02, 3, 0);
    do_write(8'h02, 6, 0);
    do_write(8'h02, 5, 4);
    do_write(8'h01, 1, 0);
    do_write(8'hC7, 2, 0);
    do_write(8'h04, 0, 7);

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      for (int i = 0; i < 8; i++) pay[i] = 8'($urandom);
      if ($urandom % 3 == 0) begin
        logic [23:0] a;
        a = ($urandom % 4 == 0) ? 24'hFFFFFD : 24'($urandom);
        do_read(1'($urandom), a, 1 + int'($urandom % 4), int'($urandom % 8));
      end else begin
        do_write(wops[$urandom % 6], int'($urandom % 7),
                 ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 7));
      end
    end

    finish_run();
  end

endmodule